// File: doc/BRIEF.md
# eFuse Access Strobe Sequencer

This block drives the control pins of an eFuse macro for a single read or a single program access. A one-cycle start pulse, together with a mode bit and a bank address, launches one access. The block then moves through five timed phases in a fixed order: control setup, address setup, strobe high, address hold and control hold. It drives the active-low chip select, the program enable, the load, the bank address and the strobe pin for the whole sequence.

Each phase length is taken from a 32-bit timing word and is counted in reference-clock cycles. Read and program accesses use separate strobe-width fields, and the program width is much wider. When the strobe falls at the end of a read, the block captures the macro's read word. After chip select has returned high it raises a one-cycle done pulse. The timing word can be rewritten only while no access is running.

Phases and transitions of the controller. IDLE goes to CTL_SETUP when start is accepted. CTL_SETUP goes to ADDR_SETUP when its count expires and the address-setup field is non-zero, and goes directly to STROBE_HIGH when that field is zero. ADDR_SETUP goes to STROBE_HIGH when its count expires. STROBE_HIGH goes to ADDR_HOLD at expiry, and a read captures its data on this edge. ADDR_HOLD goes to CTL_HOLD at expiry. CTL_HOLD returns to IDLE at expiry and raises done.

Top module: `efuse_strobe_seq`

## Requirements
- R1: After reset the outputs are fuse_csb=1, fuse_strobe=0, fuse_pgen=0, fuse_load=0, fuse_addr=0, busy=0, done=0 and rdata=0, and tim_q holds 32'h003E_8210.
- R2: When start is sampled high in IDLE, fuse_csb goes low on the next cycle. The control-setup phase then lasts ctl_setup+1 cycles, and fuse_addr stays 0 and fuse_strobe stays 0 during it.
- R3: The address-setup phase shows the latched address on fuse_addr with fuse_strobe low for exactly adr_setup cycles. When adr_setup=0 the strobe rises directly after control setup.
- R4: fuse_strobe stays high for rd_width+1 cycles on a read and wr_width+1 cycles on a program access, and fuse_addr is held for that whole time.
- R5: After the strobe falls, the address stays on fuse_addr for adr_hold+1 cycles and then returns to 0. fuse_csb stays low for a further ctl_hold+1 cycles and then returns high.
- R6: While fuse_csb is low, fuse_pgen is 1 only for a program access (wr_mode=1) and fuse_load is 1 only for a read (wr_mode=0). Both are 0 while idle.
- R7: done is high for exactly one cycle, the first cycle with fuse_csb high after an access. rdata then holds the fuse_rdata word sampled on the last strobe-high cycle of the most recent read. A program access leaves rdata unchanged.
- R8: A tim_we write updates tim_q on the next cycle only when busy is 0 and start is 0. Otherwise the write is ignored and tim_q keeps its value.
- R9: A start while busy=1 is ignored: no further access is performed and the outputs follow only the running access.
- R10: The timing word layout is ctl_setup [3:0], adr_setup [7:4], rd_width [11:8], wr_width [23:12], adr_hold [27:24] and ctl_hold [31:28], and an access uses the fields at these positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tim_we | input | 1 | Timing word write strobe |
| tim_wdata | input | 32 | Timing word write value |
| tim_q | output | 32 | Current timing word |
| start | input | 1 | Launch one access |
| wr_mode | input | 1 | 1 = program access, 0 = read access |
| addr | input | ADDR_W | Bank address for the access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last read word |
| fuse_csb | output | 1 | Macro chip select, active low |
| fuse_pgen | output | 1 | Macro program enable |
| fuse_load | output | 1 | Macro load (read) enable |
| fuse_strobe | output | 1 | Macro strobe |
| fuse_addr | output | ADDR_W | Macro bank address |
| fuse_rdata | input | DATA_W | Macro read word |

## Verification
Accesses are run with the reset timing word and then with several distinct words. Among them are zero address setup, which separates the skip path from the counted path, and all-zero fields, which expose off-by-one errors in the N+1 encodings. All-maximum fields catch a truncated counter. Reads and program accesses to different addresses tell apart the two strobe widths and the pgen/load selection, and the read words differ by address so that a misplaced capture shows up. Timing writes and starts are also applied during an access, in the same cycle as a start, and in the done cycle, which separate the lock and back-to-back acceptance rules.

// File: rtl/efs_pkg.sv
package efs_pkg;

    localparam int TIM_W   = 32;
    localparam int SHORT_W = 4;
    localparam int LONG_W  = 12;
    localparam logic [TIM_W-1:0] TIM_RESET = 32'h003E_8210;

    // Field order fixed by the timing word layout (MSB first).
    typedef struct packed {
        logic [SHORT_W-1:0] ctl_hold;
        logic [SHORT_W-1:0] adr_hold;
        logic [LONG_W-1:0]  wr_width;
        logic [SHORT_W-1:0] rd_width;
        logic [SHORT_W-1:0] adr_setup;
        logic [SHORT_W-1:0] ctl_setup;
    } efs_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL_SETUP,
        ST_ADDR_SETUP,
        ST_STROBE_HIGH,
        ST_ADDR_HOLD,
        ST_CTL_HOLD
    } efs_state_e;

endpackage

// File: rtl/efs_timing_reg.sv
module efs_timing_reg
    import efs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             lock,
    input  logic [TIM_W-1:0] wdata,
    output logic [TIM_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= TIM_RESET;
        end else if (we && !lock) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/efs_down_counter.sv
module efs_down_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/efs_read_capture.sv
module efs_read_capture #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (capture) begin
            q <= din;
        end
    end

endmodule

// File: rtl/efuse_strobe_seq.sv
module efuse_strobe_seq
    import efs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tim_we,
    input  logic [31:0]       tim_wdata,
    output logic [31:0]       tim_q,
    input  logic              start,
    input  logic              wr_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              fuse_csb,
    output logic              fuse_pgen,
    output logic              fuse_load,
    output logic              fuse_strobe,
    output logic [ADDR_W-1:0] fuse_addr,
    input  logic [DATA_W-1:0] fuse_rdata
);

    localparam int CNT_W = LONG_W;
    localparam int PAD_W = CNT_W - SHORT_W;

    efs_state_e        state, state_nx;
    efs_timing_t       tcfg;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_expired;
    logic              capture;
    logic              finish;
    logic [CNT_W-1:0]  strobe_len;

    assign busy = (state != ST_IDLE);
    assign done = done_q;

    // Timing word: frozen during an access and in the cycle a start is taken.
    efs_timing_reg u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tim_we),
        .lock  (busy || start),
        .wdata (tim_wdata),
        .q     (tim_q)
    );

    assign tcfg = efs_timing_t'(tim_q);

    assign strobe_len = wr_q ? tcfg.wr_width : {{PAD_W{1'b0}}, tcfg.rd_width};

    efs_down_counter #(.W(CNT_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    efs_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (fuse_rdata),
        .q       (rdata)
    );

    // Next phase and counter reload.
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_CTL_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = {{PAD_W{1'b0}}, tcfg.ctl_setup};
                end
            end
            ST_CTL_SETUP: begin
                if (cnt_expired) begin
                    cnt_load = 1'b1;
                    if (tcfg.adr_setup != '0) begin
                        state_nx = ST_ADDR_SETUP;
                        cnt_val  = {{PAD_W{1'b0}}, tcfg.adr_setup - 1'b1};
                    end else begin
                        state_nx = ST_STROBE_HIGH;
                        cnt_val  = strobe_len;
                    end
                end
            end
            ST_ADDR_SETUP: begin
                if (cnt_expired) begin
                    state_nx = ST_STROBE_HIGH;
                    cnt_load = 1'b1;
                    cnt_val  = strobe_len;
                end
            end
            ST_STROBE_HIGH: begin
                if (cnt_expired) begin
                    state_nx = ST_ADDR_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = {{PAD_W{1'b0}}, tcfg.adr_hold};
                    capture  = !wr_q;
                end
            end
            ST_ADDR_HOLD: begin
                if (cnt_expired) begin
                    state_nx = ST_CTL_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = {{PAD_W{1'b0}}, tcfg.ctl_hold};
                end
            end
            ST_CTL_HOLD: begin
                if (cnt_expired) begin
                    state_nx = ST_IDLE;
                    finish   = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and per-access latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= finish;
            if (state == ST_IDLE && start) begin
                wr_q   <= wr_mode;
                addr_q <= addr;
            end
        end
    end

    // Pin outputs decoded from the phase.
    always_comb begin
        fuse_csb    = 1'b1;
        fuse_pgen   = 1'b0;
        fuse_load   = 1'b0;
        fuse_strobe = 1'b0;
        fuse_addr   = '0;
        unique case (state)
            ST_IDLE: begin
                fuse_csb = 1'b1;
            end
            ST_CTL_SETUP, ST_CTL_HOLD: begin
                fuse_csb  = 1'b0;
                fuse_pgen = wr_q;
                fuse_load = !wr_q;
            end
            ST_ADDR_SETUP, ST_ADDR_HOLD: begin
                fuse_csb  = 1'b0;
                fuse_pgen = wr_q;
                fuse_load = !wr_q;
                fuse_addr = addr_q;
            end
            ST_STROBE_HIGH: begin
                fuse_csb    = 1'b0;
                fuse_pgen   = wr_q;
                fuse_load   = !wr_q;
                fuse_addr   = addr_q;
                fuse_strobe = 1'b1;
            end
            default: fuse_csb = 1'b1;
        endcase
    end

endmodule

// File: rtl/efs_checker.sv
module efs_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fuse_csb,
    input logic              fuse_pgen,
    input logic              fuse_load,
    input logic              fuse_strobe,
    input logic [ADDR_W-1:0] fuse_addr,
    input logic [31:0]       tim_q
);

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> fuse_csb && !fuse_strobe);

    assert_strobe_inside_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> !fuse_csb);

    assert_select_before_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe) |-> $past(!fuse_csb));

    assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_strobe && $past(fuse_strobe)) |-> $stable(fuse_addr));

    assert_hold_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe) |-> !fuse_csb);

    assert_mode_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_pgen && fuse_load));

    assert_mode_in_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_pgen || fuse_load) |-> !fuse_csb);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fuse_csb && $past(!fuse_csb));

    assert_timing_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(tim_q));

endmodule

bind efuse_strobe_seq efs_checker #(.ADDR_W(ADDR_W)) u_efs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .fuse_csb    (fuse_csb),
    .fuse_pgen   (fuse_pgen),
    .fuse_load   (fuse_load),
    .fuse_strobe (fuse_strobe),
    .fuse_addr   (fuse_addr),
    .tim_q       (tim_q)
);

// File: tb/efuse_strobe_seq_test.sv
module efuse_strobe_seq_test;

    localparam int AW = 7;
    localparam int DW = 128;

    typedef struct packed {
        logic [2:0]    ph;   // 0 idle,1 csu,2 asu,3 strobe,4 ahd,5 chd,6 done
        logic          dn;
        logic          csb;
        logic          stb;
        logic          pg;
        logic          ld;
        logic [AW-1:0] a;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tim_we = 1'b0;
    logic [31:0]   tim_wdata = '0;
    logic [31:0]   tim_q;
    logic          start = 1'b0;
    logic          wr_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy, done;
    logic [DW-1:0] rdata;
    logic          fuse_csb, fuse_pgen, fuse_load, fuse_strobe;
    logic [AW-1:0] fuse_addr;
    logic [DW-1:0] fuse_rdata;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    exp_t          q[$];
    logic [31:0]   model_tim = 32'h003E_8210;
    logic [DW-1:0] exp_rdata = '0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_wr = 1'b0;
    int            done_seen = 0;
    int            issued = 0;
    int            stb_run = 0;
    int            last_rd_w = 0;
    int            last_wr_w = 0;
    logic          run_wr = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] fuse_word(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++)
            w[i] = a[i % AW] ^ ((i / AW) % 2 == 1) ^ (i % 3 == 0);
        return w;
    endfunction

    assign fuse_rdata = fuse_word(fuse_addr);

    efuse_strobe_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .tim_we(tim_we), .tim_wdata(tim_wdata),
        .tim_q(tim_q), .start(start), .wr_mode(wr_mode), .addr(addr),
        .busy(busy), .done(done), .rdata(rdata), .fuse_csb(fuse_csb),
        .fuse_pgen(fuse_pgen), .fuse_load(fuse_load), .fuse_strobe(fuse_strobe),
        .fuse_addr(fuse_addr), .fuse_rdata(fuse_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic string phase_tag(input logic [2:0] ph);
        case (ph)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R7";
            default: return "R9";
        endcase
    endfunction

    function automatic exp_t mk(input logic [2:0] ph, input logic dn, input logic csb,
                                input logic stb, input logic wr, input logic [AW-1:0] a);
        exp_t e;
        e.ph = ph; e.dn = dn; e.csb = csb; e.stb = stb;
        e.pg = !csb && wr; e.ld = !csb && !wr; e.a = a;
        return e;
    endfunction

    // Builds the expected per-cycle pin sequence of one access (R10 field positions).
    task automatic push_access(input logic [31:0] t, input logic wr, input logic [AW-1:0] a);
        int csu, asu, w, ahd, chd;
        csu = int'(t[3:0]);
        asu = int'(t[7:4]);
        w   = wr ? int'(t[23:12]) : int'(t[11:8]);
        ahd = int'(t[27:24]);
        chd = int'(t[31:28]);
        for (int i = 0; i <= csu; i++) q.push_back(mk(3'd1, 1'b0, 1'b0, 1'b0, wr, '0));
        for (int i = 0; i < asu; i++)  q.push_back(mk(3'd2, 1'b0, 1'b0, 1'b0, wr, a));
        for (int i = 0; i <= w; i++)   q.push_back(mk(3'd3, 1'b0, 1'b0, 1'b1, wr, a));
        for (int i = 0; i <= ahd; i++) q.push_back(mk(3'd4, 1'b0, 1'b0, 1'b0, wr, a));
        for (int i = 0; i <= chd; i++) q.push_back(mk(3'd5, 1'b0, 1'b0, 1'b0, wr, '0));
        q.push_back(mk(3'd6, 1'b1, 1'b1, 1'b0, 1'b0, '0));
    endtask

    // Cycle-by-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (running && rst_n) begin
            exp_t e;
            string tg;
            bit cur_active;
            e = (q.size() > 0) ? q.pop_front() : mk(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
            tg = phase_tag(e.ph);
            check(fuse_csb == e.csb && fuse_strobe == e.stb && fuse_addr == e.a && done == e.dn
                  && busy == !e.csb, tg,
                  {fuse_csb, fuse_strobe, busy, done, fuse_addr},
                  {e.csb, e.stb, !e.csb, e.dn, e.a});
            check(fuse_pgen == e.pg && fuse_load == e.ld, "R6",
                  {fuse_pgen, fuse_load}, {e.pg, e.ld});
            check(tim_q == model_tim, "R8", tim_q, model_tim);
            if (e.dn) begin
                if (!acc_wr) exp_rdata = fuse_word(acc_addr);
                check(rdata == exp_rdata, "R7", rdata, exp_rdata);
            end
            if (done) done_seen++;
            if (fuse_strobe) begin
                stb_run++;
                run_wr = fuse_pgen;
            end else if (stb_run > 0) begin
                if (run_wr) last_wr_w = stb_run; else last_rd_w = stb_run;
                stb_run = 0;
            end
            cur_active = !e.csb;
            if (start && q.size() == 0) begin
                acc_addr = addr;
                acc_wr   = wr_mode;
                push_access(model_tim, wr_mode, addr);
            end
            if (tim_we && !cur_active && !start) model_tim = tim_wdata;
        end
    end

    task automatic access(input logic wr, input logic [AW-1:0] a);
        @(posedge clk); #2;
        start = 1'b1; wr_mode = wr; addr = a;
        @(posedge clk); #2;
        start = 1'b0;
        issued++;
    endtask

    task automatic set_tim(input logic [31:0] w);
        @(posedge clk); #2;
        tim_we = 1'b1; tim_wdata = w;
        @(posedge clk); #2;
        tim_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || done);
    endtask

    task automatic wait_done();
        do begin @(posedge clk); #2; end while (!done);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(fuse_csb && !fuse_strobe && !fuse_pgen && !fuse_load && fuse_addr == '0
              && !busy && !done, "R1",
              {fuse_csb, fuse_strobe, fuse_pgen, fuse_load, busy, done, fuse_addr}, 13'h1000);
        check(rdata == '0, "R1", rdata, 0);
        check(tim_q == 32'h003E_8210, "R1", tim_q, 32'h003E_8210);
        @(posedge clk); #2;
        rst_n = 1'b1;
        running = 1'b1;

        // Reset timing: read then program access.
        access(1'b0, 7'h21); wait_idle();
        access(1'b1, 7'h33); wait_idle();

        // R10: custom word, field positions used for the access.
        set_tim(32'h4200_7503);
        access(1'b0, 7'h55); wait_idle();
        check(last_rd_w == 6, "R10", last_rd_w, 6);
        access(1'b1, 7'h12); wait_idle();
        check(last_wr_w == 8, "R10", last_wr_w, 8);

        // All-zero fields, address setup skipped; back-to-back start in done cycle.
        set_tim(32'h0000_0000);
        access(1'b0, 7'h7F);
        wait_done();
        start = 1'b1; wr_mode = 1'b0; addr = 7'h0A;
        @(posedge clk); #2; start = 1'b0; issued++;
        wait_idle();

        // R8/R9: timing write and extra start during a running access are ignored.
        set_tim(32'h1131_0221);
        access(1'b0, 7'h44);
        set_tim(32'hFFFF_FFFF);
        @(posedge clk); #2; start = 1'b1; wr_mode = 1'b1; addr = 7'h01;
        @(posedge clk); #2; start = 1'b0;
        wait_idle();
        check(tim_q == 32'h1131_0221, "R8", tim_q, 32'h1131_0221);
        check(done_seen == issued, "R9", done_seen, issued);

        // R8: write in same cycle as start is ignored.
        @(posedge clk); #2;
        start = 1'b1; wr_mode = 1'b0; addr = 7'h66; tim_we = 1'b1; tim_wdata = 32'h0;
        @(posedge clk); #2; start = 1'b0; tim_we = 1'b0; issued++;
        wait_idle();
        check(tim_q == 32'h1131_0221, "R8", tim_q, 32'h1131_0221);

        // All-maximum fields.
        set_tim(32'hFFFF_FFFF);
        access(1'b0, 7'h5A); wait_idle();
        check(last_rd_w == 16, "R4", last_rd_w, 16);
        access(1'b1, 7'h2B); wait_idle();
        check(last_wr_w == 4096, "R4", last_wr_w, 4096);
        check(done_seen == issued, "R9", done_seen, issued);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule